// File: doc/BRIEF.md
# Configurable True Dual-Port RAM

A synchronous memory with two fully independent access ports, A and B, over one shared bit array. Either port can read or write in any cycle. Each port has its own data width, its own behaviour on the read output during a write, an optional second register stage on that output, and a 3-bit select value that the port's select input must match before the port does anything. Both ports sample on the rising edge of one common clock. Each port has its own clock enable.

The array is held as 2^AW9 words of 9 bits. A 9-bit port addresses one word. An 18-bit port addresses a pair of words. A 1-, 2- or 4-bit port addresses a lane inside the low 8 bits of a word. Data written through one width is therefore read back through any other width with the same bit order. A reset input clears the read output registers of both ports. A parameter makes that reset asynchronous or synchronous.

Top module: `dpram_dual`

## Requirements
- R1: WIDTH_A and WIDTH_B each take a value from 1, 2, 4, 9 or 18. A port's address has AW9-1 bits at width 18, AW9 bits at width 9, and AW9+1, AW9+2 or AW9+3 bits at width 4, 2 or 1.
- R2: Address mapping.
  - A 9-bit address a selects word a.
  - An 18-bit address a selects word 2a for data bits 8:0 and word 2a+1 for data bits 17:9.
  - A w-bit address a, with w below 9, selects word a/(8/w), starting at bit (a mod (8/w))*w.
  - Bit 8 of a word is reachable only at widths 9 and 18.
- R3: When the output register is off, a read presents the addressed data on the port's output after one active clock edge. When the output register is on, the data appears after two consecutive active edges.
- R4: In hold mode (mode value 0), the output keeps its previous value on a write cycle.
- R5: In pass mode (mode value 1), the output shows the data being written on a write cycle.
- R6: In old-data mode (mode value 2), the output shows the contents the location had before the write. This mode is legal only at widths 9 and 18; any other width stops elaboration with an error.
- R7: A port whose 3-bit select input differs from its match parameter neither writes the array nor changes its output, even with write enable high.
- R8: A port whose clock enable is low neither writes the array nor changes its output, even with write enable high.
- R9: Reset forces every output register stage to zero. With RST_SYNC=0 the clear happens as soon as reset rises. With RST_SYNC=1 it happens at the next clock edge.
- R10: Both ports may operate in the same cycle at locations in different words, and each sees its own result. If both ports write the same word in one cycle, the stored value is undefined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock, rising edge |
| rst | input | 1 | Output register reset, active high |
| ce_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| cs_a | input | 3 | Port A select, compared with CS_A |
| addr_a | input | AW_A | Port A address |
| wd_a | input | WIDTH_A | Port A write data |
| q_a | output | WIDTH_A | Port A read data |
| ce_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| cs_b | input | 3 | Port B select, compared with CS_B |
| addr_b | input | AW_B | Port B address |
| wd_b | input | WIDTH_B | Port B write data |
| q_b | output | WIDTH_B | Port B read data |

## Verification
The following are checked on every clock:
- an idle port (enable low or select mismatched) keeps its output steady;
- hold mode leaves the output unchanged on a write;
- pass mode echoes the written data, after one or two edges depending on the output register;
- reset leaves zero on the outputs.

Only the bench's sweeps can show:
- the width mapping between ports;
- the old contents returned in old-data mode;
- that an ignored write really left the array untouched;
- concurrent traffic on both ports;
- when an asynchronous clear takes effect compared with a synchronous one.

// File: rtl/dpram_dual.sv
module dpram_dual #(
  parameter int AW9 = 11,
  parameter int WIDTH_A = 1,
  parameter int WIDTH_B = 1,
  parameter int MODE_A = 0,
  parameter int MODE_B = 0,
  parameter bit OUTREG_A = 1'b0,
  parameter bit OUTREG_B = 1'b0,
  parameter bit RST_SYNC = 1'b0,
  parameter logic [2:0] CS_A = 3'd0,
  parameter logic [2:0] CS_B = 3'd0,
  localparam int AW_A = (WIDTH_A == 18) ? AW9 - 1 : (WIDTH_A == 9) ? AW9 :
                        (WIDTH_A == 4) ? AW9 + 1 : (WIDTH_A == 2) ? AW9 + 2 : AW9 + 3,
  localparam int AW_B = (WIDTH_B == 18) ? AW9 - 1 : (WIDTH_B == 9) ? AW9 :
                        (WIDTH_B == 4) ? AW9 + 1 : (WIDTH_B == 2) ? AW9 + 2 : AW9 + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_a,
  input  logic               we_a,
  input  logic [2:0]         cs_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] wd_a,
  output logic [WIDTH_A-1:0] q_a,
  input  logic               ce_b,
  input  logic               we_b,
  input  logic [2:0]         cs_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] wd_b,
  output logic [WIDTH_B-1:0] q_b
);
  localparam int NW  = 2 ** AW9;
  localparam int AWX = AW9 + 3;

  logic [8:0]     mem [NW];
  logic [AWX-1:0] addr [2];
  logic [17:0]    wd [2];
  logic           act [2];
  logic           wr [2];
  logic [AW9-1:0] i0 [2];
  logic [AW9-1:0] i1 [2];
  logic [8:0]     m0 [2];
  logic [8:0]     m1 [2];
  logic [8:0]     v0 [2];
  logic [8:0]     v1 [2];

  assign act[0]  = ce_a && (cs_a == CS_A);
  assign act[1]  = ce_b && (cs_b == CS_B);
  assign wr[0]   = act[0] && we_a;
  assign wr[1]   = act[1] && we_b;
  assign addr[0] = AWX'(addr_a);
  assign addr[1] = AWX'(addr_b);
  assign wd[0]   = 18'(wd_a);
  assign wd[1]   = 18'(wd_b);

  always_ff @(posedge clk)
    for (int p = 0; p < 2; p++)
      if (wr[p])
        for (int b = 0; b < 9; b++) begin
          if (m0[p][b]) mem[i0[p]][b] <= v0[p][b];
          if (m1[p][b]) mem[i1[p]][b] <= v1[p][b];
        end

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int W  = (p == 0) ? WIDTH_A : WIDTH_B;
    localparam int M  = (p == 0) ? MODE_A : MODE_B;
    localparam bit OR = (p == 0) ? OUTREG_A : OUTREG_B;

    logic [17:0] rd, s1, s2, n1, n2;
    logic        unused_bits;
    assign unused_bits = ^{addr[p], wd[p]};

    if (M == 2 && W < 9) begin : g_bad_mode
      $error("old-data mode requires a 9 or 18 bit port");
    end

    if (W == 18) begin : g_w18
      assign i0[p] = {addr[p][AW9-2:0], 1'b0};
      assign i1[p] = {addr[p][AW9-2:0], 1'b1};
      assign m0[p] = 9'h1ff;
      assign m1[p] = 9'h1ff;
      assign v0[p] = wd[p][8:0];
      assign v1[p] = wd[p][17:9];
      assign rd    = {mem[i1[p]], mem[i0[p]]};
    end else if (W == 9) begin : g_w9
      assign i0[p] = addr[p][AW9-1:0];
      assign i1[p] = addr[p][AW9-1:0];
      assign m0[p] = 9'h1ff;
      assign m1[p] = 9'h000;
      assign v0[p] = wd[p][8:0];
      assign v1[p] = 9'h000;
      assign rd    = {9'h000, mem[i0[p]]};
    end else begin : g_narrow
      localparam int SH = $clog2(8 / W);
      localparam logic [8:0] LM = 9'((1 << W) - 1);
      logic [3:0] lo;
      assign lo    = 4'(addr[p][SH-1:0]) * 4'(W);
      assign i0[p] = addr[p][SH +: AW9];
      assign i1[p] = addr[p][SH +: AW9];
      assign m0[p] = LM << lo;
      assign m1[p] = 9'h000;
      assign v0[p] = wd[p][8:0] << lo;
      assign v1[p] = 9'h000;
      assign rd    = 18'((mem[i0[p]] >> lo) & LM);
    end

    always_comb begin
      n1 = s1;
      n2 = s2;
      if (act[p]) begin
        n2 = s1;
        if (!wr[p] || M == 2) n1 = rd;
        else if (M == 1)      n1 = wd[p];
      end
    end

    if (RST_SYNC) begin : g_srst
      always_ff @(posedge clk)
        if (rst) begin s1 <= '0; s2 <= '0; end
        else     begin s1 <= n1; s2 <= n2; end
    end else begin : g_arst
      always_ff @(posedge clk or posedge rst)
        if (rst) begin s1 <= '0; s2 <= '0; end
        else     begin s1 <= n1; s2 <= n2; end
    end

    if (p == 0) begin : g_qa
      assign q_a = OR ? s2[WIDTH_A-1:0] : s1[WIDTH_A-1:0];
    end else begin : g_qb
      assign q_b = OR ? s2[WIDTH_B-1:0] : s1[WIDTH_B-1:0];
    end
  end
endmodule

// File: rtl/dpram_dual_chk.sv
module dpram_dual_chk #(
  parameter int WIDTH_A = 1,
  parameter int WIDTH_B = 1,
  parameter int MODE_A = 0,
  parameter int MODE_B = 0,
  parameter bit OUTREG_A = 1'b0,
  parameter bit OUTREG_B = 1'b0,
  parameter logic [2:0] CS_A = 3'd0,
  parameter logic [2:0] CS_B = 3'd0
) (
  input logic               clk,
  input logic               rst,
  input logic               ce_a,
  input logic               we_a,
  input logic [2:0]         cs_a,
  input logic [WIDTH_A-1:0] wd_a,
  input logic [WIDTH_A-1:0] q_a,
  input logic               ce_b,
  input logic               we_b,
  input logic [2:0]         cs_b,
  input logic [WIDTH_B-1:0] wd_b,
  input logic [WIDTH_B-1:0] q_b
);
  logic on_a, on_b, unused_chk;
  assign on_a = ce_a && (cs_a == CS_A);
  assign on_b = ce_b && (cs_b == CS_B);
  assign unused_chk = ^{wd_a, wd_b, we_a, we_b};

  p_idle_hold_a_r7: assert property (@(posedge clk) disable iff (rst)
    !on_a |=> q_a === $past(q_a));
  p_idle_hold_b_r7: assert property (@(posedge clk) disable iff (rst)
    !on_b |=> q_b === $past(q_b));

  p_reset_clear_a_r9: assert property (@(posedge clk) rst |=> q_a == '0);
  p_reset_clear_b_r9: assert property (@(posedge clk) rst |=> q_b == '0);

  if (MODE_A == 0 && !OUTREG_A) begin : g_hold_a
    p_normal_hold_a_r4: assert property (@(posedge clk) disable iff (rst)
      on_a && we_a |=> q_a === $past(q_a));
  end
  if (MODE_B == 0 && !OUTREG_B) begin : g_hold_b
    p_normal_hold_b_r4: assert property (@(posedge clk) disable iff (rst)
      on_b && we_b |=> q_b === $past(q_b));
  end

  if (MODE_A == 1 && !OUTREG_A) begin : g_wt_a
    p_wt_echo_a_r5: assert property (@(posedge clk) disable iff (rst)
      on_a && we_a |=> q_a === $past(wd_a));
  end else if (MODE_A == 1) begin : g_wt_a2
    p_wt_echo2_a_r5: assert property (@(posedge clk) disable iff (rst)
      on_a && we_a ##1 on_a |=> q_a === $past(wd_a, 2));
  end
  if (MODE_B == 1 && !OUTREG_B) begin : g_wt_b
    p_wt_echo_b_r5: assert property (@(posedge clk) disable iff (rst)
      on_b && we_b |=> q_b === $past(wd_b));
  end else if (MODE_B == 1) begin : g_wt_b2
    p_wt_echo2_b_r5: assert property (@(posedge clk) disable iff (rst)
      on_b && we_b ##1 on_b |=> q_b === $past(wd_b, 2));
  end
endmodule

bind dpram_dual dpram_dual_chk #(
  .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .MODE_A(MODE_A), .MODE_B(MODE_B),
  .OUTREG_A(OUTREG_A), .OUTREG_B(OUTREG_B), .CS_A(CS_A), .CS_B(CS_B)
) u_chk (
  .clk(clk), .rst(rst),
  .ce_a(ce_a), .we_a(we_a), .cs_a(cs_a), .wd_a(wd_a), .q_a(q_a),
  .ce_b(ce_b), .we_b(we_b), .cs_b(cs_b), .wd_b(wd_b), .q_b(q_b)
);

// File: tb/dpram_dual_test.sv
module dpram_dual_harness #(
  parameter int AW9 = 4,
  parameter int WA = 9,
  parameter int WB = 18,
  parameter int MA = 0,
  parameter int MB = 0,
  parameter bit RA = 1'b0,
  parameter bit RB = 1'b0,
  parameter bit RS = 1'b0,
  parameter logic [2:0] CA = 3'd0,
  parameter logic [2:0] CB = 3'd0
) (
  input  logic clk,
  output logic done,
  output int   nchk,
  output int   nfail
);
  localparam int NW  = 2 ** AW9;
  localparam int AWA = (WA == 18) ? AW9 - 1 : (WA == 9) ? AW9 : (WA == 4) ? AW9 + 1 : (WA == 2) ? AW9 + 2 : AW9 + 3;
  localparam int AWB = (WB == 18) ? AW9 - 1 : (WB == 9) ? AW9 : (WB == 4) ? AW9 + 1 : (WB == 2) ? AW9 + 2 : AW9 + 3;
  localparam int NAA = 2 ** AWA;
  localparam int NBB = 2 ** AWB;

  logic rst, ce_a, we_a, ce_b, we_b;
  logic [2:0] cs_a, cs_b;
  logic [AWA-1:0] addr_a;
  logic [AWB-1:0] addr_b;
  logic [WA-1:0] wd_a, q_a;
  logic [WB-1:0] wd_b, q_b;

  dpram_dual #(.AW9(AW9), .WIDTH_A(WA), .WIDTH_B(WB), .MODE_A(MA), .MODE_B(MB),
    .OUTREG_A(RA), .OUTREG_B(RB), .RST_SYNC(RS), .CS_A(CA), .CS_B(CB)) uut (
    .clk(clk), .rst(rst),
    .ce_a(ce_a), .we_a(we_a), .cs_a(cs_a), .addr_a(addr_a), .wd_a(wd_a), .q_a(q_a),
    .ce_b(ce_b), .we_b(we_b), .cs_b(cs_b), .addr_b(addr_b), .wd_b(wd_b), .q_b(q_b));

  logic [8:0]  mdl [NW];
  logic [17:0] s1a, s2a, s1b, s2b;

  function automatic int bix(int w, int a, int j);
    if (w == 18) return (2 * a + j / 9) * 9 + j % 9;
    if (w == 9) return a * 9 + j;
    return (a / (8 / w)) * 9 + (a % (8 / w)) * w + j;
  endfunction

  function automatic logic [17:0] mrd(int w, int a);
    logic [17:0] v = '0;
    for (int j = 0; j < w; j++) begin
      int k = bix(w, a, j);
      v[j] = mdl[k / 9][k % 9];
    end
    return v;
  endfunction

  task automatic mwr(int w, int a, logic [17:0] d);
    for (int j = 0; j < w; j++) begin
      int k = bix(w, a, j);
      mdl[k / 9][k % 9] = d[j];
    end
  endtask

  function automatic logic [17:0] pat(int a, int salt);
    return 18'(((a * 37 + salt * 101 + 11) ^ (a << 7)) + salt * 4099);
  endfunction

  function automatic string tagm(int m);
    return (m == 0) ? "R4" : (m == 1) ? "R5" : "R6";
  endfunction

  task automatic chk(logic [17:0] got, logic [17:0] exp, string what);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic step(bit cea, bit oka, bit wea, int aa, logic [17:0] da,
                      bit ceb, bit okb, bit web, int ab, logic [17:0] db, string what);
    logic [17:0] oa, ob;
    bit acta = cea && oka;
    bit actb = ceb && okb;
    bit xa, xb;
    ce_a = cea; cs_a = oka ? CA : CA ^ 3'd1; we_a = wea; addr_a = AWA'(aa); wd_a = da[WA-1:0];
    ce_b = ceb; cs_b = okb ? CB : CB ^ 3'd1; we_b = web; addr_b = AWB'(ab); wd_b = db[WB-1:0];
    oa = mrd(WA, aa);
    ob = mrd(WB, ab);
    if (acta) begin
      s2a = s1a;
      if (!wea || MA == 2) s1a = oa;
      else if (MA == 1) s1a = 18'(da[WA-1:0]);
    end
    if (actb) begin
      s2b = s1b;
      if (!web || MB == 2) s1b = ob;
      else if (MB == 1) s1b = 18'(db[WB-1:0]);
    end
    if (acta && wea) mwr(WA, aa, da);
    if (actb && web) mwr(WB, ab, db);
    @(posedge clk); @(negedge clk);
    xa = acta && RA;
    xb = actb && RB;
    if (xa || xb) begin
      ce_a = xa; cs_a = CA; we_a = 1'b0;
      ce_b = xb; cs_b = CB; we_b = 1'b0;
      if (xa) begin s2a = s1a; s1a = mrd(WA, aa); end
      if (xb) begin s2b = s1b; s1b = mrd(WB, ab); end
      @(posedge clk); @(negedge clk);
    end
    ce_a = 1'b0; we_a = 1'b0; ce_b = 1'b0; we_b = 1'b0;
    chk(18'(q_a), RA ? s2a : s1a, {what, " port A"});
    chk(18'(q_b), RB ? s2b : s1b, {what, " port B"});
  endtask

  initial begin
    int n;
    done = 1'b0; nchk = 0; nfail = 0;
    rst = 1'b1; ce_a = 0; we_a = 0; cs_a = CA; addr_a = '0; wd_a = '0;
    ce_b = 0; we_b = 0; cs_b = CB; addr_b = '0; wd_b = '0;
    s1a = '0; s2a = '0; s1b = '0; s2b = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(18'(q_a), '0, "R9 reset state A");
    chk(18'(q_b), '0, "R9 reset state B");
    rst = 1'b0;
    for (int a = 0; a < NAA; a++)
      step(1, 1, 1, a, pat(a, 1), 0, 1, 0, 0, '0, {"R1 R3 write A ", tagm(MA)});
    for (int b = 0; b < NBB; b++)
      step(0, 1, 0, 0, '0, 1, 1, 0, b, '0, "R2 R3 read B");
    for (int b = 0; b < NBB; b++)
      step(0, 1, 0, 0, '0, 1, 1, 1, b, pat(b, 2), {"R1 write B ", tagm(MB)});
    for (int a = 0; a < NAA; a++)
      step(1, 1, 0, a, '0, 0, 1, 0, 0, '0, "R2 R3 read A");
    n = ((NAA < NBB) ? NAA : NBB) / 2;
    for (int i = 0; i < n; i++)
      step(1, 1, (i % 2 == 0), i, pat(i, 3), 1, 1, (i % 2 != 0), NBB / 2 + i, pat(i, 4), "R10 concurrent");
    step(1, 0, 1, 3, ~pat(3, 5), 0, 1, 0, 0, '0, "R7 select mismatch A");
    step(1, 1, 0, 3, '0, 0, 1, 0, 0, '0, "R7 readback A");
    step(0, 1, 0, 0, '0, 1, 0, 1, 1, ~pat(1, 6), "R7 select mismatch B");
    step(0, 1, 0, 0, '0, 1, 1, 0, 1, '0, "R7 readback B");
    step(0, 1, 1, 2, ~pat(2, 7), 0, 1, 0, 0, '0, "R8 enable low A");
    step(1, 1, 0, 2, '0, 0, 1, 0, 0, '0, "R8 readback A");
    step(0, 1, 0, 0, '0, 0, 1, 1, 0, ~pat(0, 8), "R8 enable low B");
    step(0, 1, 0, 0, '0, 1, 1, 0, 0, '0, "R8 readback B");
    for (int b = 0; b < NBB; b++)
      step(0, 1, 0, 0, '0, 1, 1, 0, b, '0, "R2 final sweep B");
    rst = 1'b1;
    #2;
    chk(18'(q_a), RS ? (RA ? s2a : s1a) : '0, "R9 reset timing A");
    chk(18'(q_b), RS ? (RB ? s2b : s1b) : '0, "R9 reset timing B");
    @(posedge clk); @(negedge clk);
    chk(18'(q_a), '0, "R9 reset after edge A");
    chk(18'(q_b), '0, "R9 reset after edge B");
    rst = 1'b0;
    done = 1'b1;
  end
endmodule

module dpram_dual_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic d0, d1, d2;
  int c0, c1, c2, f0, f1, f2;

  dpram_dual_harness #(.WA(9), .WB(18), .MA(0), .MB(2), .RA(1'b0), .RB(1'b1),
    .RS(1'b0), .CA(3'd5), .CB(3'd2)) h0 (.clk(clk), .done(d0), .nchk(c0), .nfail(f0));
  dpram_dual_harness #(.WA(1), .WB(4), .MA(1), .MB(0), .RA(1'b1), .RB(1'b0),
    .RS(1'b1), .CA(3'd0), .CB(3'd7)) h1 (.clk(clk), .done(d1), .nchk(c1), .nfail(f1));
  dpram_dual_harness #(.WA(2), .WB(18), .MA(1), .MB(0), .RA(1'b0), .RB(1'b1),
    .RS(1'b0), .CA(3'd3), .CB(3'd4)) h2 (.clk(clk), .done(d2), .nchk(c2), .nfail(f2));

  initial begin
    int cyc = 0;
    int checks, fails;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    #5;
    checks = c0 + c1 + c2;
    fails = f0 + f1 + f2;
    if (cyc >= 100000) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog expired: got timeout expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule